// File: doc/BRIEF.md
# Synchronous Dual-Ratio Clock Divider

This block derives two divided clock signals from one input clock. Both are produced as registered outputs in the input clock domain. One output runs at half the input rate. The other runs at a quarter or a sixth of the input rate, picked by a ratio-select input. Both outputs advance on the same rising edge, so every rising edge of the slower output falls on a rising edge of the faster one. A phase flag marks the input period that follows each such shared rising edge. Other logic uses this flag to line itself up with the divided clocks.

A freeze input stops both dividers. It is sampled by a register on the falling edge of the input clock, so a freeze or resume only takes effect at the next rising edge. A change that lands within the low half of the clock therefore cannot cut a divided pulse short. Freezing works as a clock enable on the divider registers; the clock itself is never gated.

An active-low reset acts at once when asserted and is released through a synchroniser. After reset, both outputs are low and their first rising edges coincide. A change of ratio is taken up only at a shared rising edge, so the slow output never produces a shortened high or low phase.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: While running, `half_o` toggles on every rising edge of `clk`, giving a square wave at half the input frequency.
- R2: With `ratio_sel_i` = 0, `slow_o` is high for 2 input periods, then low for 2.
- R3: With `ratio_sel_i` = 1, `slow_o` is high for 3 input periods, then low for 3.
- R4: Every rising edge of `slow_o` occurs on the same clock edge as a rising edge of `half_o`.
- R5: `phase_o` goes high on the edge where `half_o` and `slow_o` both rise, and stays high for exactly one input period. It is low at all other times.
- R6: If `freeze_i` is 1 at a falling edge of `clk`, the next rising edge leaves `half_o` and `slow_o` unchanged and drives `phase_o` low.
- R7: `freeze_i` is only looked at on falling edges. A pulse that starts after one falling edge and ends before the next has no effect on the outputs.
- R8: A new `ratio_sel_i` value is taken up only at a rising edge of `slow_o`. The phase of `slow_o` that is under way when the input changes keeps its old length.
- R9: While `rst_n` is low, `half_o`, `slow_o` and `phase_o` are low. This holds immediately when reset is asserted, without waiting for a clock edge.
- R10: After `rst_n` rises, the first two rising edges of `clk` do not advance the dividers. On the third rising edge, `half_o` and `slow_o` both rise and `phase_o` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze_i | input | 1 | 1 stops the dividers; sampled on the falling edge |
| ratio_sel_i | input | 1 | Slow-output ratio: 0 divides by 4, 1 divides by 6 |
| half_o | output | 1 | Input clock divided by 2 |
| slow_o | output | 1 | Input clock divided by 4 or 6 |
| phase_o | output | 1 | One-period flag after a shared rising edge |

## Verification
A corrupted half-period counter shows at `slow_o` as a high or low phase of the wrong length. It is visible within one slow period, which is at most six input cycles. A misaligned slow divider shows at its next rising edge, because `half_o` does not rise with it and `phase_o` either stays low or pulses at the wrong place. A wrong freeze register is visible at the very next rising edge, because the outputs advance or hold against what was sampled at the falling edge. The bench compares all three outputs against an independent phase model on every cycle, so any such fault is reported within a few cycles.

// File: rtl/dual_ratio_clkdiv_pkg.sv
`timescale 1ns/1ps
package dual_ratio_clkdiv_pkg;

  // Half-period lengths, counted in input clock cycles, for the two slow ratios
  localparam int unsigned HALF_LEN_SEL0 = 2;
  localparam int unsigned HALF_LEN_SEL1 = 3;

  // Counter width large enough to hold the longer half-period minus one
  function automatic int unsigned half_cnt_width(input int unsigned len_a,
                                                 input int unsigned len_b);
    int unsigned longest;
    longest = (len_a > len_b) ? len_a : len_b;
    return (longest < 3) ? 1 : $clog2(longest);
  endfunction

endpackage

// File: rtl/clkdiv_rst_sync.sv
`timescale 1ns/1ps
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/clkdiv_freeze_sampler.sv
`timescale 1ns/1ps
module clkdiv_freeze_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze_i,
  output logic freeze_q
);

  // Captured while the clock is low, so the rising edge that uses it
  // always sees a value that settled during the low phase.
  logic freeze_d;

  always_comb freeze_d = freeze_i;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) freeze_q <= 1'b0;
    else        freeze_q <= freeze_d;
  end

endmodule

// File: rtl/clkdiv_ratio_div.sv
`timescale 1ns/1ps
module clkdiv_ratio_div #(
  parameter int unsigned HALF_A = dual_ratio_clkdiv_pkg::HALF_LEN_SEL0,
  parameter int unsigned HALF_B = dual_ratio_clkdiv_pkg::HALF_LEN_SEL1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic sel_i,
  output logic out_o,
  output logic rise_o
);

  localparam int unsigned CNT_W    = dual_ratio_clkdiv_pkg::half_cnt_width(HALF_A, HALF_B);
  localparam int unsigned HALF_MAX = (HALF_A > HALF_B) ? HALF_A : HALF_B;
  localparam logic [CNT_W-1:0] RELOAD_A = CNT_W'(HALF_A - 1);
  localparam logic [CNT_W-1:0] RELOAD_B = CNT_W'(HALF_B - 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(HALF_MAX - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             sel_q, sel_d;
  logic             edge_now;
  logic             rise_now;
  logic             sel_next;

  // Remaining cycles in the current half-period reach zero: toggle now
  always_comb edge_now = adv_i && (cnt_q == '0);
  always_comb rise_now = edge_now && !out_q;

  // The ratio is re-read only when a rising edge starts a new period
  always_comb sel_next = rise_now ? sel_i : sel_q;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    sel_d = sel_next;
    if (edge_now) begin
      out_d = !out_q;
      cnt_d = sel_next ? RELOAD_B : RELOAD_A;
    end else if (adv_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
      sel_q <= sel_d;
    end
  end

  assign out_o  = out_q;
  assign rise_o = rise_now;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP); // R3

  AST_SEL_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_now |=> $stable(sel_q)); // R8

  AST_STOPPED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(out_q) && $stable(cnt_q)); // R6

endmodule

// File: rtl/dual_ratio_clkdiv.sv
`timescale 1ns/1ps
module dual_ratio_clkdiv #(
  parameter int unsigned HALF_A     = dual_ratio_clkdiv_pkg::HALF_LEN_SEL0,
  parameter int unsigned HALF_B     = dual_ratio_clkdiv_pkg::HALF_LEN_SEL1,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze_i,
  input  logic ratio_sel_i,
  output logic half_o,
  output logic slow_o,
  output logic phase_o
);

  logic rst_n_int;
  logic freeze_q;
  logic run;
  logic slow_rise;
  logic slow_q;
  logic half_q, half_d;
  logic phase_q, phase_d;

  clkdiv_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  clkdiv_freeze_sampler u_freeze (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .freeze_i (freeze_i),
    .freeze_q (freeze_q)
  );

  always_comb run = !freeze_q;

  clkdiv_ratio_div #(.HALF_A(HALF_A), .HALF_B(HALF_B)) u_slow (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .adv_i  (run),
    .sel_i  (ratio_sel_i),
    .out_o  (slow_q),
    .rise_o (slow_rise)
  );

  // Divide-by-2 stage shares the clock enable of the slow divider
  always_comb half_d = run ? !half_q : half_q;

  // Flag the period that begins with a shared rising edge
  always_comb phase_d = slow_rise && !half_q;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      half_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      half_q  <= half_d;
      phase_q <= phase_d;
    end
  end

  assign half_o  = half_q;
  assign slow_o  = slow_q;
  assign phase_o = phase_q;

  AST_HALF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n_int)
    !freeze_q |=> (half_q != $past(half_q))); // R1

  AST_SHARED_RISE: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(slow_q) |-> $rose(half_q)); // R4

  AST_PHASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    phase_q |=> !phase_q); // R5

  AST_PHASE_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n_int)
    phase_q |-> (half_q && slow_q)); // R5

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_int)
    freeze_q |=> ($stable(half_q) && $stable(slow_q) && !phase_q)); // R6

endmodule

// File: tb/tb_dual_ratio_clkdiv.sv
`timescale 1ns/1ps
module tb_dual_ratio_clkdiv;

  logic clk = 1'b0;
  logic rst_n;
  logic freeze;
  logic sel;
  logic half, slow, phase;

  int checks = 0;
  int errors = 0;
  int p  = 0;   // position inside the slow period, 0 = last low cycle
  int pl = 4;   // current slow period length

  always #5 clk = ~clk;

  dual_ratio_clkdiv dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .freeze_i    (freeze),
    .ratio_sel_i (sel),
    .half_o      (half),
    .slow_o      (slow),
    .phase_o     (phase)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One rising edge; model advances unless the edge is expected to be frozen
  task automatic step(input string tag, input bit frozen);
    bit   reload;
    logic s;
    @(posedge clk);
    s = sel;
    #2;
    reload = 1'b0;
    if (!frozen) begin
      if (p == 0) begin
        pl = s ? 6 : 4;
        p = 1;
        reload = 1'b1;
      end else begin
        p = (p + 1) % pl;
      end
    end
    chk({tag, " R1 half"}, half, logic'(p % 2 == 1));
    chk({tag, (pl == 6) ? " R3 slow" : " R2 slow"}, slow, logic'(p >= 1 && p <= pl / 2));
    chk({tag, " R5 phase"}, phase, logic'(reload));
  endtask

  task automatic release_reset();
    @(posedge clk);
    #2 rst_n = 1'b1;
    p = 0;
    step("R10 sync1", 1'b1);
    step("R10 sync2", 1'b1);
    step("R10 first", 1'b0);
    chk("R10 both rise", half & slow & phase, 1'b1);
  endtask

  task automatic t_power_reset();
    rst_n = 1'b0; freeze = 1'b0; sel = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 half low", half, 1'b0);
    chk("R9 slow low", slow, 1'b0);
    chk("R9 phase low", phase, 1'b0);
    release_reset();
  endtask

  task automatic t_div4();
    sel = 1'b0;
    for (int i = 0; i < 12; i++) step("R2 div4", 1'b0);
  endtask

  task automatic t_div6();
    sel = 1'b1;
    for (int i = 0; i < 20; i++) step("R3 div6", 1'b0);
  endtask

  task automatic t_freeze();
    while (p != 1) step("R6 align", 1'b0);
    freeze = 1'b1;
    for (int i = 0; i < 3; i++) step("R6 frozen", 1'b1);
    freeze = 1'b0;
    for (int i = 0; i < 6; i++) step("R6 resume", 1'b0);
  endtask

  task automatic t_freeze_phase();
    // pulse lies between two falling edges: never sampled
    #4 freeze = 1'b1;
    #2 freeze = 1'b0;
    step("R7 missed pulse", 1'b0);
    // pulse spans a falling edge: one edge frozen
    #1 freeze = 1'b1;
    #4 freeze = 1'b0;
    step("R7 caught pulse", 1'b1);
    step("R7 after pulse", 1'b0);
    step("R7 after pulse", 1'b0);
  endtask

  task automatic t_ratio_switch();
    sel = 1'b0;
    while (p != 2) step("R8 align", 1'b0);
    sel = 1'b1;
    for (int i = 0; i < 14; i++) step("R8 to six", 1'b0);
    while (p != 3) step("R8 align", 1'b0);
    sel = 1'b0;
    for (int i = 0; i < 12; i++) step("R8 to four", 1'b0);
  endtask

  task automatic t_async_reset();
    while (p != 1) step("R9 align", 1'b0);
    #1 rst_n = 1'b0;
    #1;
    chk("R9 async half", half, 1'b0);
    chk("R9 async slow", slow, 1'b0);
    chk("R9 async phase", phase, 1'b0);
    release_reset();
    for (int i = 0; i < 8; i++) step("R2 after reset", 1'b0);
  endtask

  initial begin
    t_power_reset();
    t_div4();
    t_freeze();
    t_freeze_phase();
    t_ratio_switch();
    t_div6();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule